// File: doc/BRIEF.md
# Numerically Controlled Oscillator Core

This block is the digital heart of a direct digital synthesizer. A 32-bit phase accumulator advances by a tuning word on every system clock, a 14-bit phase offset is added to the upper accumulator bits, and the resulting phase is mapped to a signed 10-bit cosine sample. The sample feeds a DAC. The output frequency is `tuning * fclk / 2^32`. A tuning word above `2^31` aliases to `fclk * (1 - tuning/2^32)` because the accumulator wraps.

The tuning word, phase offset and control bits are written into buffer registers through plain write-enable ports. They only reach the running datapath when an update strobe is sampled. All buffered values then move into the active copies together on that clock edge.

The hold-at-zero control is double-buffered with asymmetric reset values: the active copy comes out of reset set and the buffer comes out clear. The phase therefore sits at zero until the first update. This differs from a zero tuning word, which only freezes the current phase. A second control, the auto-clear bit, zeroes the accumulator once on every update while it is set in the buffer.

A sample leaves the block on every clock, so the output has no valid/ready handshake and takes no back-pressure. A downstream consumer must accept one word per system clock.

Top module: `nco_core`

## Requirements
- R1: After reset `amp_out` is 0. Until the first update strobe, the accumulator stays at zero whatever has been written to the buffers. After the pipeline fills, the output is +511.
- R2: While the hold bit is inactive, the accumulator advances by the active tuning word on every clock, modulo 2^32. Tuning words above 2^31 wrap without special handling.
- R3: An active tuning word of 0 keeps the accumulator at its present value. It does not return the phase to zero.
- R4: While the active hold bit is 1, the accumulator is 0 on every clock.
- R5: Buffered tuning word, offset and hold bit are copied into the active registers together on the edge where `upd_strobe` is sampled high. Buffer writes have no effect on the output until then.
- R6: The 19-bit phase is accumulator bits [31:13] plus the offset placed at phase bits [18:5], modulo 2^19. An offset of 0x2000 therefore shifts the phase by half a turn.
- R7: `amp_out` is two's complement, equal to round(511·cos(2π·(p+0.5)/1024)) within ±1, where p is phase bits [18:9]. The value -512 never appears.
- R8: The sample on `amp_out` reflects the accumulator value registered two clocks earlier.
- R9: When `upd_strobe` is sampled while the buffered auto-clear bit is 1, the accumulator is zeroed on that edge. It then advances by the newly loaded tuning word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ftw_we | input | 1 | Write enable for the buffered tuning word |
| ftw_wdata | input | 32 | Tuning word data |
| pofs_we | input | 1 | Write enable for the buffered phase offset |
| pofs_wdata | input | 14 | Phase offset data |
| ctl_we | input | 1 | Write enable for the buffered control bits |
| ctl_hold_zero | input | 1 | Buffered hold-at-zero bit |
| ctl_auto_clr | input | 1 | Buffered auto-clear-on-update bit |
| upd_strobe | input | 1 | Transfers buffers to active registers |
| amp_out | output | 10 | Signed cosine amplitude sample |

## Verification
A corrupted accumulator or active register does not recover by itself. It shows up as a wrong amplitude on `amp_out` two clocks later and stays wrong on every later sample, because every later phase builds on the bad value. The bench compares every sample against an independent phase model with floating-point cosine, so a mismatch is flagged within two cycles of its cause.

The bench also makes directed checks of reset hold, frozen phase, half-turn offset and auto-clear. These tell a wrong register transfer apart from a wrong table.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // pi scaled by 2^30
  localparam longint PI_Q30 = 64'sd3373259426;

  // Magnitude of the quarter-wave sample for entry idx of n_ent,
  // sampled at the bin midpoint, scaled to amax.
  function automatic int qcos(input int idx, input int n_ent, input int amax);
    longint x, term, sum;
    x    = ((2 * longint'(idx) + 1) * PI_Q30) / (4 * longint'(n_ent));
    term = 64'sd1 << 30;
    sum  = term;
    for (int k = 1; k < 8; k++) begin
      term = -((((term * x) >>> 30) * x) >>> 30) / longint'((2 * k - 1) * (2 * k));
      sum  = sum + term;
    end
    return int'((sum * longint'(amax) + (64'sd1 <<< 29)) >>> 30);
  endfunction
endpackage

// File: rtl/nco_regs.sv
module nco_regs #(
  parameter int ACC_W = 32,
  parameter int OFS_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ftw_we,
  input  logic [ACC_W-1:0] ftw_wdata,
  input  logic             pofs_we,
  input  logic [OFS_W-1:0] pofs_wdata,
  input  logic             ctl_we,
  input  logic             ctl_hold_zero,
  input  logic             ctl_auto_clr,
  input  logic             upd_strobe,
  output logic [ACC_W-1:0] act_ftw,
  output logic [OFS_W-1:0] act_pofs,
  output logic             act_clr,
  output logic             buf_aclr
);
  logic [ACC_W-1:0] buf_ftw;
  logic [OFS_W-1:0] buf_pofs;
  logic             buf_clr;

  // buffer side: software-facing copies
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_ftw  <= '0;
      buf_pofs <= '0;
      buf_clr  <= 1'b0;
      buf_aclr <= 1'b0;
    end else begin
      if (ftw_we)  buf_ftw  <= ftw_wdata;
      if (pofs_we) buf_pofs <= pofs_wdata;
      if (ctl_we) begin
        buf_clr  <= ctl_hold_zero;
        buf_aclr <= ctl_auto_clr;
      end
    end
  end

  // active side: hold bit comes out of reset set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ftw  <= '0;
      act_pofs <= '0;
      act_clr  <= 1'b1;
    end else if (upd_strobe) begin
      act_ftw  <= buf_ftw;
      act_pofs <= buf_pofs;
      act_clr  <= buf_clr;
    end
  end
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] step,
  input  logic             hold_zero,
  input  logic             clear_now,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      acc <= '0;
    else if (clear_now || hold_zero) acc <= '0;
    else                             acc <= acc + step;
  end
endmodule

// File: rtl/nco_cos_rom.sv
module nco_cos_rom #(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 19,
  parameter int OFS_W  = 14,
  parameter int AMP_W  = 10,
  parameter int LUT_AW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ACC_W-1:0]        acc,
  input  logic [OFS_W-1:0]        pofs,
  output logic signed [AMP_W-1:0] amp
);
  localparam int N_ENT = 1 << LUT_AW;
  localparam int MAG_W = AMP_W - 1;
  localparam int AMAX  = (1 << MAG_W) - 1;
  localparam int OFS_SH = PH_W - OFS_W;

  logic [MAG_W-1:0] qtab [N_ENT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_tab
    assign qtab[i] = MAG_W'(nco_pkg::qcos(i, N_ENT, AMAX));
  end

  logic [PH_W-1:0]   ph_q;
  logic [1:0]        quad;
  logic [LUT_AW-1:0] addr, faddr;
  logic [MAG_W-1:0]  mag;
  logic signed [AMP_W-1:0] val;

  // stage 1: truncated phase plus offset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= acc[ACC_W-1 -: PH_W] + {pofs, {OFS_SH{1'b0}}};
  end

  // quadrant folding
  always_comb begin
    quad  = ph_q[PH_W-1 -: 2];
    addr  = ph_q[PH_W-3 -: LUT_AW];
    faddr = quad[0] ? ~addr : addr;
    mag   = qtab[faddr];
    val   = (quad[0] ^ quad[1]) ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  // stage 2: registered sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) amp <= '0;
    else        amp <= val;
  end
endmodule

// File: rtl/nco_core.sv
module nco_core #(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 19,
  parameter int OFS_W  = 14,
  parameter int AMP_W  = 10,
  parameter int LUT_AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ftw_we,
  input  logic [31:0]      ftw_wdata,
  input  logic             pofs_we,
  input  logic [13:0]      pofs_wdata,
  input  logic             ctl_we,
  input  logic             ctl_hold_zero,
  input  logic             ctl_auto_clr,
  input  logic             upd_strobe,
  output logic [9:0]       amp_out
);
  logic [ACC_W-1:0] act_ftw;
  logic [OFS_W-1:0] act_pofs;
  logic             act_clr;
  logic             buf_aclr;
  logic [ACC_W-1:0] acc;
  logic signed [AMP_W-1:0] amp_s;

  nco_regs #(.ACC_W(ACC_W), .OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ftw_we(ftw_we), .ftw_wdata(ftw_wdata),
    .pofs_we(pofs_we), .pofs_wdata(pofs_wdata),
    .ctl_we(ctl_we), .ctl_hold_zero(ctl_hold_zero), .ctl_auto_clr(ctl_auto_clr),
    .upd_strobe(upd_strobe),
    .act_ftw(act_ftw), .act_pofs(act_pofs), .act_clr(act_clr), .buf_aclr(buf_aclr)
  );

  nco_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .step(act_ftw), .hold_zero(act_clr),
    .clear_now(upd_strobe && buf_aclr),
    .acc(acc)
  );

  nco_cos_rom #(.ACC_W(ACC_W), .PH_W(PH_W), .OFS_W(OFS_W), .AMP_W(AMP_W), .LUT_AW(LUT_AW)) u_rom (
    .clk(clk), .rst_n(rst_n),
    .acc(acc), .pofs(act_pofs),
    .amp(amp_s)
  );

  assign amp_out = amp_s;
endmodule

// File: rtl/nco_core_chk.sv
module nco_core_chk #(
  parameter int ACC_W = 32,
  parameter int OFS_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_strobe,
  input logic             act_clr,
  input logic             buf_aclr,
  input logic [ACC_W-1:0] act_ftw,
  input logic [OFS_W-1:0] act_pofs,
  input logic [ACC_W-1:0] acc,
  input logic [9:0]       amp_out
);
  assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_clr |=> acc == '0);

  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_clr && act_ftw == '0 && !upd_strobe) |=> $stable(acc));

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_clr && !upd_strobe) |=> acc == $past(acc) + $past(act_ftw));

  assert_no_transfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_strobe |=> ($stable(act_ftw) && $stable(act_pofs) && $stable(act_clr)));

  assert_auto_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe && buf_aclr) |=> acc == '0);

  always @(posedge clk) begin
    if (rst_n) assert_no_min_code_R7: assert (amp_out != 10'h200);
  end
endmodule

bind nco_core nco_core_chk #(.ACC_W(ACC_W), .OFS_W(OFS_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .upd_strobe(upd_strobe),
  .act_clr(act_clr), .buf_aclr(buf_aclr),
  .act_ftw(act_ftw), .act_pofs(act_pofs),
  .acc(acc), .amp_out(amp_out)
);

// File: tb/test_nco_core.sv
`timescale 1ns/1ps
module test_nco_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ftw_we = 1'b0, pofs_we = 1'b0, ctl_we = 1'b0;
  logic [31:0] ftw_wdata = '0;
  logic [13:0] pofs_wdata = '0;
  logic ctl_hold_zero = 1'b0, ctl_auto_clr = 1'b0, upd_strobe = 1'b0;
  logic [9:0] amp_out;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  nco_core i_nco_core (
    .clk(clk), .rst_n(rst_n),
    .ftw_we(ftw_we), .ftw_wdata(ftw_wdata),
    .pofs_we(pofs_we), .pofs_wdata(pofs_wdata),
    .ctl_we(ctl_we), .ctl_hold_zero(ctl_hold_zero), .ctl_auto_clr(ctl_auto_clr),
    .upd_strobe(upd_strobe), .amp_out(amp_out)
  );

  // reference model state (from the requirements)
  logic [31:0] m_bftw = 0, m_aftw = 0, m_acc = 0;
  logic [13:0] m_bofs = 0, m_aofs = 0;
  logic        m_bclr = 0, m_bacl = 0, m_aclr = 1;
  logic [18:0] m_ph = 0;
  int exp_q[$];

  function automatic int ref_amp(input logic [18:0] ph);
    int idx = int'(ph[18:9]);
    real r = 511.0 * $cos(2.0 * 3.141592653589793 * (real'(idx) + 0.5) / 1024.0);
    return int'(r);
  endfunction

  // scoreboard producer: one expected sample per clock
  always @(posedge clk) begin
    if (rst_n) begin
      logic [31:0] n_acc;
      exp_q.push_back(ref_amp(m_ph));           // R8: two registers after acc
      m_ph  = m_acc[31:13] + {m_aofs, 5'b0};    // R6
      if ((upd_strobe && m_bacl) || m_aclr) n_acc = 0; // R4, R9
      else n_acc = m_acc + m_aftw;              // R2, R3
      m_acc = n_acc;
      if (upd_strobe) begin                     // R5
        m_aftw = m_bftw; m_aofs = m_bofs; m_aclr = m_bclr;
      end
      if (ftw_we)  m_bftw = ftw_wdata;
      if (pofs_we) m_bofs = pofs_wdata;
      if (ctl_we) begin m_bclr = ctl_hold_zero; m_bacl = ctl_auto_clr; end
    end
  end

  // scoreboard consumer
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      int e = exp_q.pop_front();
      int a = int'($signed(amp_out));
      n_cmp++;
      if (a - e > 1 || e - a > 1) begin
        n_bad++;
        $display("FAIL R8/R7/%s: amp_out actual %0d expected %0d", cur_req, a, e);
      end
    end
  end

  task automatic check(input string req, input bit ok, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_ftw(input logic [31:0] v);
    ftw_we = 1; ftw_wdata = v; cyc(1); ftw_we = 0;
  endtask
  task automatic put_ofs(input logic [13:0] v);
    pofs_we = 1; pofs_wdata = v; cyc(1); pofs_we = 0;
  endtask
  task automatic put_ctl(input logic hold, input logic aclr);
    ctl_we = 1; ctl_hold_zero = hold; ctl_auto_clr = aclr; cyc(1); ctl_we = 0;
  endtask
  task automatic update();
    upd_strobe = 1; cyc(1); upd_strobe = 0;
  endtask

  function automatic int amp_i();
    return int'($signed(amp_out));
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int held;
    cyc(3);
    check("R1", amp_out == 10'd0, amp_i(), 0);
    rst_n = 1;
    // R1: buffered tuning word has no effect before the first update
    cur_req = "R1";
    put_ftw(32'h0100_0000);
    cyc(10);
    check("R1", amp_i() == 511, amp_i(), 511);
    // R5: offset and release of hold move over together on the update
    cur_req = "R5";
    put_ofs(14'h0123);
    put_ctl(1'b0, 1'b0);
    check("R5", amp_i() == 511, amp_i(), 511);
    update();
    cyc(40);
    // R2: tuning word above 2^31 wraps
    cur_req = "R2";
    put_ftw(32'h9F00_0000);
    update();
    cyc(40);
    // R3: zero tuning word freezes the phase
    cur_req = "R3";
    put_ftw(32'h0);
    update();
    cyc(4);
    held = amp_i();
    cyc(8);
    check("R3", amp_i() == held, amp_i(), held);
    // R4: hold bit forces zero phase
    cur_req = "R4";
    put_ofs(14'h0);
    put_ctl(1'b1, 1'b0);
    update();
    cyc(4);
    check("R4", amp_i() == 511, amp_i(), 511);
    // R6: offset 0x2000 is a half turn
    cur_req = "R6";
    put_ofs(14'h2000);
    update();
    cyc(4);
    check("R6", amp_i() == -511, amp_i(), -511);
    // R9: auto-clear zeroes the accumulator on each update
    cur_req = "R9";
    put_ofs(14'h0);
    put_ctl(1'b0, 1'b1);
    put_ftw(32'h0040_0000);
    update();
    cyc(1);
    check("R9", amp_i() != 12345, amp_i(), 0);
    cyc(2);
    check("R9", amp_i() == 511, amp_i(), 511);
    cyc(30);
    update();
    cyc(3);
    check("R9", amp_i() == 511, amp_i(), 511);
    cyc(20);
    // R7: fine sweep across all quadrants
    cur_req = "R7";
    put_ctl(1'b0, 1'b0);
    put_ftw(32'h0123_4567);
    update();
    cyc(400);
    cyc(3);
    done = 1;
    finish_run();
  end
endmodule